// File: doc/BRIEF.md
# Four-Stage Interlocked Integer Pipeline

An in-order integer core with four stages: instruction fetch, decode with register read, operate, and write-back. A buffer register separates each pair of stages. The fetch-to-decode buffer carries only the instruction word. The decode-to-operate buffer carries both operand values, the operation and the destination register. The operate-to-write buffer carries the result and the destination. The core executes register-to-register and immediate ALU instructions out of a 16-entry register file. It has no data memory and no branches, so the fetch address only counts upward.

Instruction memory answers combinationally on `imem_data`, and it signals with `imem_ready` when the word is valid. A slow fetch holds the fetch address steady, and each waiting cycle becomes a bubble that travels down the pipe. A read-after-write hazard is resolved in one of two ways, chosen at build time by the `FORWARD` parameter:
- **Forwarding:** the operate-stage result is fed back into the decode operand path, so dependent instructions issue back to back.
- **Interlock:** decode holds the instruction until the producer reaches write-back.

In both cases the register file passes a same-cycle write through to its readers. Each completed instruction pulses the retire port once, with its destination and the value written.

Top module: `pipe4_core`

## Requirements
- R1: In the first cycle after reset is released, `ret_valid` is 0 and `imem_addr` is 0. The register file resets to all zeros.
- R2: Instructions are encoded as opcode [15:12], destination [11:8], source 1 [7:4], and source 2 or immediate [3:0]. The opcodes are: 1 adds source 1 and source 2, 2 subtracts source 2 from source 1, 3 shifts source 1 left by the immediate, 4 loads the zero-extended immediate, and 5 adds source 1 and the zero-extended immediate. Results wrap at the data width.
- R3: Opcode 0 and opcodes 6 to 15 do not retire and change no register.
- R4: Register 0 always reads as zero. A write to it is discarded, and such an instruction retires with destination 0 and value 0. Register 0 never causes a stall.
- R5: Every instruction with opcode 1 to 5 retires exactly once, in program order. On its retire, `ret_dest` and `ret_value` give the destination and the value computed from the program-order register state.
- R6: An instruction accepted by `imem_ready` at the end of cycle c is reported on the retire port in cycle c+3, unless it is stalled.
- R7: While `imem_ready` is low, `imem_addr` holds its value. When a fetch waits for L cycles, the following instruction retires exactly L cycles later than it would have otherwise. On an accepted fetch the address advances by one.
- R8: With `FORWARD`=1, an instruction that reads the destination of the instruction immediately before it issues with no bubble and receives the new value.
- R9: With `FORWARD`=0, that immediately dependent case costs exactly one bubble. A dependency at distance two or more, or through register 0, costs none, and a fetch wait of one cycle or more hides the bubble entirely.
- R10: When write-back writes a register in the same cycle that decode reads it, decode receives the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | AW | Fetch address (instruction index) |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| imem_ready | input | 1 | Instruction word valid this cycle |
| ret_valid | output | 1 | One-cycle pulse per retired instruction |
| ret_dest | output | 4 | Destination register of the retiring instruction |
| ret_value | output | DW | Value written by the retiring instruction |

## Verification
Two pairs of events can land in the same cycle, and each pair is provoked on purpose.

The first pair is a data hazard and a fetch wait. The bench runs one program with chained dependencies through a forwarding build and through an interlocked build. Each build is run once with a memory that answers at once and once with a two-cycle fetch latency. This shows whether a stall bubble and a memory bubble add up or overlap.

The second pair is a write-back and a decode read of the same register, reached through dependencies at distance two.

Each retire is judged against a one-instruction-at-a-time model on three points: destination, value, and the exact cycle. The cycle is computed from the fetch latency and from the count of adjacent dependencies.

// File: rtl/pipe4_pkg.sv
// pipe4_pkg: instruction encoding shared by the pipeline modules.
// Assumes a fixed 16-bit instruction with four 4-bit fields.
package pipe4_pkg;
    localparam int IW  = 16;
    localparam int OPW = 4;
    localparam int RW  = 4;
    localparam int NREG = 1 << RW;

    localparam logic [OPW-1:0] OP_NOP  = 4'd0;
    localparam logic [OPW-1:0] OP_ADD  = 4'd1;
    localparam logic [OPW-1:0] OP_SUB  = 4'd2;
    localparam logic [OPW-1:0] OP_SHL  = 4'd3;
    localparam logic [OPW-1:0] OP_LDI  = 4'd4;
    localparam logic [OPW-1:0] OP_ADDI = 4'd5;

    typedef struct packed {
        logic           vld;
        logic [OPW-1:0] op;
        logic [RW-1:0]  rd;
    } stage_ctl_t;
endpackage

// File: rtl/pipe4_regfile.sv
// pipe4_regfile: register file with two read ports and one write port.
// Register 0 is not stored and always reads as zero. A write in the same
// cycle as a read of that register is passed through to the reader.
module pipe4_regfile
    import pipe4_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [RW-1:0] ra0,
    input  logic [RW-1:0] ra1,
    output logic [DW-1:0] rd0,
    output logic [DW-1:0] rd1
);
    logic [DW-1:0] mem [1:NREG-1];

    // Storage update: clear on reset, write the addressed register otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < NREG; i++) mem[i] <= '0;
        end else if (we && wa != '0) begin
            mem[wa] <= wd;
        end
    end

    // Read ports with zero register and write-through bypass.
    always_comb begin
        if (ra0 == '0)                rd0 = '0;
        else if (we && wa == ra0)     rd0 = wd;
        else                          rd0 = mem[ra0];
        if (ra1 == '0)                rd1 = '0;
        else if (we && wa == ra1)     rd1 = wd;
        else                          rd1 = mem[ra1];
    end
endmodule

// File: rtl/pipe4_alu.sv
// pipe4_alu: combinational operate-stage unit.
// Assumes the immediate is already zero-extended into operand b.
module pipe4_alu
    import pipe4_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output logic [DW-1:0]  y
);
    localparam int SHW = $clog2(DW);

    // Operation select.
    always_comb begin
        case (op)
            OP_ADD, OP_ADDI: y = a + b;
            OP_SUB:          y = a - b;
            OP_SHL:          y = a << b[SHW-1:0];
            OP_LDI:          y = b;
            default:         y = '0;
        endcase
    end
endmodule

// File: rtl/pipe4_hazard.sv
// pipe4_hazard: decide the decode operands and the decode stall.
// With FORWARD=1 a match against the operate stage takes the ALU result.
// With FORWARD=0 such a match stalls decode for one cycle, and the register
// file bypass then supplies the value. Register 0 never matches.
module pipe4_hazard
    import pipe4_pkg::*;
#(
    parameter int DW      = 16,
    parameter bit FORWARD = 1'b1
) (
    input  logic          fd_vld,
    input  logic [RW-1:0] rs0,
    input  logic [RW-1:0] rs1,
    input  logic          use0,
    input  logic          use1,
    input  logic [DW-1:0] rf0,
    input  logic [DW-1:0] rf1,
    input  logic          ex_vld,
    input  logic [RW-1:0] ex_rd,
    input  logic [DW-1:0] ex_res,
    output logic [DW-1:0] opv0,
    output logic [DW-1:0] opv1,
    output logic          stall
);
    logic [RW-1:0] rs   [2];
    logic          use_ [2];
    logic [DW-1:0] rf   [2];
    logic [DW-1:0] opv  [2];
    logic [1:0]    hit;

    assign rs[0] = rs0;    assign rs[1] = rs1;
    assign use_[0] = use0; assign use_[1] = use1;
    assign rf[0] = rf0;    assign rf[1] = rf1;

    for (genvar j = 0; j < 2; j++) begin : g_src
        // Source j matches the producer in the operate stage.
        assign hit[j] = use_[j] && (rs[j] != '0) && ex_vld && (ex_rd == rs[j]);
        // Source j operand value, forwarded when the variant allows it.
        assign opv[j] = (FORWARD && hit[j]) ? ex_res : rf[j];
    end

    assign opv0  = opv[0];
    assign opv1  = opv[1];
    assign stall = !FORWARD && fd_vld && (|hit);
endmodule

// File: rtl/pipe4_core.sv
// pipe4_core: four-stage in-order integer pipeline (fetch, decode/read,
// operate, write). Assumes combinational instruction memory qualified by
// imem_ready. There are no branches, so the fetch address only increments.
module pipe4_core
    import pipe4_pkg::*;
#(
    parameter int DW      = 16,
    parameter int AW      = 8,
    parameter bit FORWARD = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] imem_addr,
    input  logic [IW-1:0] imem_data,
    input  logic          imem_ready,
    output logic          ret_valid,
    output logic [RW-1:0] ret_dest,
    output logic [DW-1:0] ret_value
);
    // Fetch state and fetch/decode buffer.
    logic [AW-1:0] pc;
    logic          fd_vld;
    logic [IW-1:0] fd_ins;
    // Decode/operate and operate/write buffers.
    stage_ctl_t    do_ctl, ow_ctl;
    logic [DW-1:0] do_a, do_b, ow_res;

    logic [OPW-1:0] dec_op;
    logic [RW-1:0]  dec_rd, dec_s0, dec_s1;
    logic           dec_legal, dec_use0, dec_use1, dec_imm;
    logic [DW-1:0]  rf0, rf1, opv0, opv1, alu_y;
    logic           stall;

    assign imem_addr = pc;

    // Fetch: capture a word when memory is ready, or insert a bubble; hold while decode stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            fd_vld <= 1'b0;
            fd_ins <= '0;
        end else if (!stall) begin
            fd_vld <= imem_ready;
            fd_ins <= imem_data;
            if (imem_ready) pc <= pc + 1'b1;
        end
    end

    // Decode: split the instruction fields and classify the opcode.
    always_comb begin
        dec_op    = fd_ins[15:12];
        dec_rd    = fd_ins[11:8];
        dec_s0    = fd_ins[7:4];
        dec_s1    = fd_ins[3:0];
        dec_legal = (dec_op >= OP_ADD) && (dec_op <= OP_ADDI);
        dec_use0  = (dec_op == OP_ADD) || (dec_op == OP_SUB) ||
                    (dec_op == OP_SHL) || (dec_op == OP_ADDI);
        dec_use1  = (dec_op == OP_ADD) || (dec_op == OP_SUB);
        dec_imm   = (dec_op == OP_SHL) || (dec_op == OP_LDI) || (dec_op == OP_ADDI);
    end

    pipe4_regfile #(.DW(DW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(ow_ctl.vld), .wa(ow_ctl.rd), .wd(ow_res),
        .ra0(dec_s0), .ra1(dec_s1), .rd0(rf0), .rd1(rf1)
    );

    pipe4_hazard #(.DW(DW), .FORWARD(FORWARD)) u_hz (
        .fd_vld(fd_vld), .rs0(dec_s0), .rs1(dec_s1),
        .use0(dec_use0), .use1(dec_use1), .rf0(rf0), .rf1(rf1),
        .ex_vld(do_ctl.vld), .ex_rd(do_ctl.rd), .ex_res(alu_y),
        .opv0(opv0), .opv1(opv1), .stall(stall)
    );

    // Decode/operate buffer: operands, operation and destination, or a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            do_ctl <= '0;
            do_a   <= '0;
            do_b   <= '0;
        end else begin
            do_ctl.vld <= fd_vld && dec_legal && !stall;
            do_ctl.op  <= dec_op;
            do_ctl.rd  <= dec_rd;
            do_a       <= opv0;
            do_b       <= dec_imm ? {{(DW-RW){1'b0}}, dec_s1} : opv1;
        end
    end

    pipe4_alu #(.DW(DW)) u_alu (.op(do_ctl.op), .a(do_a), .b(do_b), .y(alu_y));

    // Operate/write buffer: result and destination; writes to register 0 read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ow_ctl <= '0;
            ow_res <= '0;
        end else begin
            ow_ctl <= do_ctl;
            ow_res <= (do_ctl.rd == '0) ? '0 : alu_y;
        end
    end

    assign ret_valid = ow_ctl.vld;
    assign ret_dest  = ow_ctl.rd;
    assign ret_value = ow_res;
endmodule

// File: rtl/pipe4_chk.sv
// pipe4_chk: port-level properties of pipe4_core, bound to every instance.
module pipe4_chk #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] imem_addr,
    input logic          imem_ready,
    input logic          ret_valid,
    input logic [3:0]    ret_dest,
    input logic [DW-1:0] ret_value
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ret_valid && imem_addr == '0));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !imem_ready |=> $stable(imem_addr));

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imem_ready |=> ($stable(imem_addr) || imem_addr == $past(imem_addr) + 1'b1));

    // R4
    zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_dest == 4'd0) |-> (ret_value == '0));
endmodule

bind pipe4_core pipe4_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_ready(imem_ready),
    .ret_valid(ret_valid), .ret_dest(ret_dest), .ret_value(ret_value)
);

// File: tb/pipe4_core_tb.sv
// Bench: one program through a forwarding and an interlocked build, each at
// fetch latency 0 and 2, compared every cycle with a behavioural model.
module pipe4_core_tb;
    localparam int DW = 16, AW = 8, PLEN = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;
    logic rst_n = 1'b0;

    logic [AW-1:0] a_f, a_n;
    logic          r_f = 1'b0, r_n = 1'b0;
    logic [15:0]   d_f, d_n;
    logic          v_f, v_n;
    logic [3:0]    dr_f, dr_n;
    logic [DW-1:0] rv_f, rv_n;
    logic [15:0]   rom [0:255];

    assign d_f = rom[a_f];
    assign d_n = rom[a_n];

    pipe4_core #(.DW(DW), .AW(AW), .FORWARD(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(a_f), .imem_data(d_f), .imem_ready(r_f),
        .ret_valid(v_f), .ret_dest(dr_f), .ret_value(rv_f));
    pipe4_core #(.DW(DW), .AW(AW), .FORWARD(1'b0)) u_dut_nf (
        .clk(clk), .rst_n(rst_n), .imem_addr(a_n), .imem_data(d_n), .imem_ready(r_n),
        .ret_valid(v_n), .ret_dest(dr_n), .ret_value(rv_n));

    int vectors = 0, errors = 0;
    int cyc, lat, exp_n, got_f, got_n, wt_f, wt_n;
    logic [AW-1:0] held_f, held_n;
    logic [3:0]  exp_rd  [0:31];
    logic [15:0] exp_val [0:31];
    int          exp_idx [0:31];
    int          dsum    [0:31];

    function automatic logic [15:0] mk(int op, int rd, int s1, int s2);
        return {op[3:0], rd[3:0], s1[3:0], s2[3:0]};
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, expv, cyc);
        end
    endtask

    // Program-order model: registers, retire list and running dependency count.
    task automatic build_model();
        logic [15:0] r [16];
        int deps = 0;
        bit plegal = 0;
        logic [3:0] prd = 0;
        for (int i = 0; i < 16; i++) r[i] = 0;
        exp_n = 0;
        for (int i = 0; i < PLEN; i++) begin
            logic [3:0] op, rd, s1, s2;
            logic [15:0] v;
            bit legal, u1, u2;
            {op, rd, s1, s2} = rom[i];
            legal = (op >= 1 && op <= 5);
            u1 = (op == 1 || op == 2 || op == 3 || op == 5);
            u2 = (op == 1 || op == 2);
            if (plegal && prd != 0 && ((u1 && s1 == prd) || (u2 && s2 == prd))) deps++;
            case (op)
                1: v = r[s1] + r[s2];
                2: v = r[s1] - r[s2];
                3: v = r[s1] << s2;
                4: v = {12'd0, s2};
                5: v = r[s1] + {12'd0, s2};
                default: v = 0;
            endcase
            if (legal) begin
                if (rd != 0) r[rd] = v;
                exp_rd[exp_n]  = rd;
                exp_val[exp_n] = (rd == 0) ? 16'd0 : v;
                exp_idx[exp_n] = i;
                dsum[exp_n]    = deps;
                exp_n++;
            end
            plegal = legal;
            prd = rd;
        end
    endtask

    // Compare one retire of either build with the model, including its cycle.
    task automatic mon(bit nf, logic v, logic [3:0] dr, logic [15:0] rv, inout int got);
        int ec;
        string ct;
        if (!v) return;
        if (got >= exp_n) begin
            check(0, "R3", nf ? "nf extra retire" : "fw extra retire", got + 1, exp_n);
            return;
        end
        ec = lat + 3 + exp_idx[got] * (lat + 1) + ((nf && lat == 0) ? dsum[got] : 0);
        ct = nf ? ((lat == 0) ? "R9" : "R9 R7") : ((lat == 0) ? "R6 R8" : "R6 R7");
        check(dr == exp_rd[got], "R5", nf ? "nf dest" : "fw dest", dr, exp_rd[got]);
        check(rv == exp_val[got], "R2 R4 R10", nf ? "nf value" : "fw value", rv, exp_val[got]);
        check(cyc == ec, ct, nf ? "nf retire cycle" : "fw retire cycle", cyc, ec);
        got++;
    endtask

    // Latency-controlled memory: ready after the address has been stable lat cycles.
    task automatic mem_step();
        if (a_f != held_f) begin held_f = a_f; wt_f = 0; end
        r_f = (wt_f >= lat); wt_f++;
        if (a_n != held_n) begin held_n = a_n; wt_n = 0; end
        r_n = (wt_n >= lat); wt_n++;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
        rom[0]  = mk(4, 1, 0, 5);
        rom[1]  = mk(4, 2, 0, 3);
        rom[2]  = mk(1, 3, 1, 2);
        rom[3]  = mk(2, 4, 3, 1);
        rom[4]  = mk(3, 5, 4, 4);
        rom[5]  = mk(5, 5, 5, 15);
        rom[6]  = mk(0, 0, 0, 0);
        rom[7]  = mk(1, 6, 5, 5);
        rom[8]  = mk(2, 7, 2, 6);
        rom[9]  = mk(9, 7, 1, 1);
        rom[10] = mk(1, 8, 7, 0);
        rom[11] = mk(4, 0, 0, 9);
        rom[12] = mk(1, 9, 0, 8);
        rom[13] = mk(3, 10, 9, 15);
        rom[14] = mk(1, 10, 10, 10);
        rom[15] = mk(5, 11, 10, 1);
        build_model();

        for (int p = 0; p < 2; p++) begin
            lat = (p == 0) ? 0 : 2;
            rst_n = 1'b0;
            r_f = 1'b0; r_n = 1'b0;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            cyc = 0;
            got_f = 0; got_n = 0;
            held_f = '1; held_n = '1;
            // R1: reset state seen at the ports
            check(v_f == 1'b0 && v_n == 1'b0, "R1", "ret_valid after reset", v_f | v_n, 0);
            check(a_f == 0 && a_n == 0, "R1", "imem_addr after reset", a_f | a_n, 0);
            mem_step();
            for (int c = 1; c <= 150; c++) begin
                @(negedge clk);
                cyc = c;
                mon(1'b0, v_f, dr_f, rv_f, got_f);
                mon(1'b1, v_n, dr_n, rv_n, got_n);
                mem_step();
            end
            // R3: only opcodes 1..5 retire, each once
            check(got_f == exp_n, "R3", "fw retire count", got_f, exp_n);
            check(got_n == exp_n, "R3", "nf retire count", got_n, exp_n);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule